// File: doc/BRIEF.md
# Bus-Host Address Byte Sequencer

This block feeds client address bytes to a serial bus transmit shift register while the controller is acting as bus host. When the address phase is requested, it picks each byte from the right place and issues a one-cycle load strobe with that byte. In buffered operation the byte comes from one of two address holding registers. In software-fed operation it comes from a transmit buffer written by firmware. It then waits for the bit engine to report whether the client acknowledged.

Three modes are supported: 7-bit addressing, 10-bit addressing, and multi-host operation. Multi-host operation is limited to 7-bit addresses. For a 10-bit address, the byte carrying the upper address bits and the R/W bit goes out first. The lower eight address bits are loaded only after that first byte has been acknowledged. A NACK on any byte ends the sequence and raises a nack strobe for the Stop logic. An ACK on the final address byte raises a done strobe, which hands control to the data phase. Generating Start and Stop, and shifting bits onto the wire, are handled elsewhere.

Top module: `hadr_tx_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `shift_load_o`, `txb_take_o`, `done_o`, `nack_o` and `busy_o` are all low.
- R2: In 7-bit mode (`mode_i`=0) with buffering on (`buf_off_i`=0), a `start_i` pulse makes `shift_load_o` high in the next cycle, with `shift_byte_o` equal to `abuf1_i` and `txb_take_o` low.
- R3: With buffering off (`buf_off_i`=1) and `txb_full_i` high, each address byte is taken from `txb_data_i`. `txb_take_o` pulses in the same cycle as the matching `shift_load_o`, and never without it.
- R4: With buffering off and `txb_full_i` low when a byte is due, no load is issued and `busy_o` stays high. The byte is loaded in the cycle after `txb_full_i` is first seen high.
- R5: In 10-bit mode (`mode_i`=1) with buffering on, `abuf1_i` is loaded first. `abuf0_i` is loaded in the cycle after an ACK (`ack_valid_i`=1, `ack_nack_i`=0) for the first byte.
- R6: In 10-bit mode with buffering off, both bytes come from the transmit buffer. Each byte waits for `txb_full_i` independently.
- R7: Multi-host mode (`mode_i`=2) and the unused code 3 behave as 7-bit mode: a single byte from `abuf1_i`, then done after its ACK.
- R8: A NACK (`ack_valid_i`=1, `ack_nack_i`=1) on any address byte gives a one-cycle `nack_o` in the next cycle and ends the sequence. Any remaining 10-bit low byte is skipped.
- R9: An ACK on the last address byte gives a one-cycle `done_o` in the next cycle, after which `busy_o` is low.
- R10: `start_i` is ignored while a sequence is in progress. Mode and buffering choice are fixed at the start, and later changes have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin address phase (strobe) |
| mode_i | input | 2 | 0: 7-bit, 1: 10-bit, 2: multi-host, 3: as 7-bit |
| buf_off_i | input | 1 | 1: address buffers unused, transmit buffer supplies bytes |
| abuf0_i | input | 8 | Address buffer 0 (10-bit low byte) |
| abuf1_i | input | 8 | Address buffer 1 (7-bit address or 10-bit high byte, with R/W) |
| txb_data_i | input | 8 | Software transmit buffer contents |
| txb_full_i | input | 1 | Transmit buffer holds an unsent byte |
| ack_valid_i | input | 1 | Bit engine reports the acknowledge slot result |
| ack_nack_i | input | 1 | 1: client did not acknowledge |
| shift_load_o | output | 1 | Load shift register strobe |
| shift_byte_o | output | 8 | Byte to load |
| txb_take_o | output | 1 | Transmit buffer byte consumed |
| done_o | output | 1 | Address phase acknowledged (strobe) |
| nack_o | output | 1 | Address byte not acknowledged (strobe) |
| busy_o | output | 1 | Sequence in progress |

## Verification
The main function is driven through each mode with distinct byte values in the two address buffers and the transmit buffer. A wrong source selection therefore shows up as a wrong byte.

- Buffered 7-bit and multi-host runs separate the 7-bit path from the 10-bit path: they must end after one ACK.
- Buffered and software-fed 10-bit runs show whether the low byte is tied to the ACK and drawn from the right source.
- Runs with an empty transmit buffer separate "wait" from "load stale data".
- NACKs on the high byte and on the low byte show that the sequence stops early.
- Start pulses during a sequence, together with a mid-sequence mode change, show that the configuration is fixed at the start.

// File: rtl/hadr_pkg.sv
package hadr_pkg;
  typedef enum logic [1:0] {
    HM_7BIT  = 2'd0,
    HM_10BIT = 2'd1,
    HM_MULTI = 2'd2,
    HM_RSVD  = 2'd3
  } hmode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WTXB = 2'd1,
    ST_AHI  = 2'd2,
    ST_ALO  = 2'd3
  } hstate_e;
endpackage

// File: rtl/hadr_src_sel.sv
module hadr_src_sel #(
  parameter int W = 8
) (
  input  logic         use_txb_i,
  input  logic         sel_lo_i,
  input  logic [W-1:0] abuf0_i,
  input  logic [W-1:0] abuf1_i,
  input  logic [W-1:0] txb_i,
  output logic [W-1:0] byte_o
);
  always_comb begin
    if (use_txb_i)     byte_o = txb_i;
    else if (sel_lo_i) byte_o = abuf0_i;
    else               byte_o = abuf1_i;
  end
endmodule

// File: rtl/hadr_fsm.sv
module hadr_fsm
  import hadr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  input  logic       buf_off_i,
  input  logic       txb_full_i,
  input  logic       ack_valid_i,
  input  logic       ack_nack_i,
  output logic       load_o,
  output logic       sel_lo_o,
  output logic       use_txb_o,
  output logic       done_o,
  output logic       nack_o,
  output logic       busy_o
);
  hstate_e st_q, st_d;
  logic    is10_q, is10_d;
  logic    off_q, off_d;
  logic    lo_q, lo_d;

  always_comb begin
    st_d      = st_q;
    is10_d    = is10_q;
    off_d     = off_q;
    lo_d      = lo_q;
    load_o    = 1'b0;
    sel_lo_o  = 1'b0;
    use_txb_o = 1'b0;
    done_o    = 1'b0;
    nack_o    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          is10_d    = (hmode_e'(mode_i) == HM_10BIT);
          off_d     = buf_off_i;
          lo_d      = 1'b0;
          use_txb_o = buf_off_i;
          if (buf_off_i && !txb_full_i) begin
            st_d = ST_WTXB;
          end else begin
            load_o = 1'b1;
            st_d   = ST_AHI;
          end
        end
      end
      ST_WTXB: begin
        use_txb_o = 1'b1;
        sel_lo_o  = lo_q;
        if (txb_full_i) begin
          load_o = 1'b1;
          st_d   = lo_q ? ST_ALO : ST_AHI;
        end
      end
      ST_AHI: begin
        if (ack_valid_i) begin
          if (ack_nack_i) begin
            nack_o = 1'b1;
            st_d   = ST_IDLE;
          end else if (is10_q) begin
            sel_lo_o  = 1'b1;
            use_txb_o = off_q;
            lo_d      = 1'b1;
            if (off_q && !txb_full_i) begin
              st_d = ST_WTXB;
            end else begin
              load_o = 1'b1;
              st_d   = ST_ALO;
            end
          end else begin
            done_o = 1'b1;
            st_d   = ST_IDLE;
          end
        end
      end
      ST_ALO: begin
        if (ack_valid_i) begin
          nack_o = ack_nack_i;
          done_o = !ack_nack_i;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      is10_q <= 1'b0;
      off_q  <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      is10_q <= is10_d;
      off_q  <= off_d;
      lo_q   <= lo_d;
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  // R10: a start pulse mid-sequence never aborts the sequence
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && start_i && !ack_valid_i) |=> (st_q != ST_IDLE));

  // R4: waiting on an empty transmit buffer keeps waiting
  assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WTXB && !txb_full_i) |=> (st_q == ST_WTXB));
endmodule

// File: rtl/hadr_tx_seq.sv
module hadr_tx_seq
  import hadr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   mode_i,
  input  logic         buf_off_i,
  input  logic [W-1:0] abuf0_i,
  input  logic [W-1:0] abuf1_i,
  input  logic [W-1:0] txb_data_i,
  input  logic         txb_full_i,
  input  logic         ack_valid_i,
  input  logic         ack_nack_i,
  output logic         shift_load_o,
  output logic [W-1:0] shift_byte_o,
  output logic         txb_take_o,
  output logic         done_o,
  output logic         nack_o,
  output logic         busy_o
);
  logic         load_c, sel_lo_c, use_txb_c, done_c, nack_c;
  logic [W-1:0] byte_c;
  logic         load_q, take_q, done_q, nack_q;
  logic [W-1:0] byte_q;

  hadr_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .buf_off_i  (buf_off_i),
    .txb_full_i (txb_full_i),
    .ack_valid_i(ack_valid_i),
    .ack_nack_i (ack_nack_i),
    .load_o     (load_c),
    .sel_lo_o   (sel_lo_c),
    .use_txb_o  (use_txb_c),
    .done_o     (done_c),
    .nack_o     (nack_c),
    .busy_o     (busy_o)
  );

  hadr_src_sel #(.W(W)) u_sel (
    .use_txb_i(use_txb_c),
    .sel_lo_i (sel_lo_c),
    .abuf0_i  (abuf0_i),
    .abuf1_i  (abuf1_i),
    .txb_i    (txb_data_i),
    .byte_o   (byte_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      take_q <= 1'b0;
      done_q <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      load_q <= load_c;
      take_q <= load_c && use_txb_c;
      done_q <= done_c;
      nack_q <= nack_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byte_q <= '0;
    else if (load_c) byte_q <= byte_c;
  end

  assign shift_load_o = load_q;
  assign shift_byte_o = byte_q;
  assign txb_take_o   = take_q;
  assign done_o       = done_q;
  assign nack_o       = nack_q;

  // R3: a buffer take always comes with a shift load
  assert_take_needs_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txb_take_o |-> shift_load_o);

  // R8: nack strobe follows a reported NACK
  assert_nack_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |-> $past(ack_valid_i && ack_nack_i));

  // R9: done strobe follows a reported ACK and ends the sequence
  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(ack_valid_i && !ack_nack_i) && !busy_o));

  // R10: a load is only ever issued inside an active sequence
  assert_load_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shift_load_o |-> busy_o);
endmodule

// File: tb/tb_hadr_tx_seq.sv
module tb_hadr_tx_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       buf_off_i = 1'b0;
  logic [7:0] abuf0_i = 8'h00;
  logic [7:0] abuf1_i = 8'h00;
  logic [7:0] txb_data_i = 8'h00;
  logic       txb_full_i = 1'b0;
  logic       ack_valid_i = 1'b0;
  logic       ack_nack_i = 1'b0;
  logic       shift_load_o, txb_take_o, done_o, nack_o, busy_o;
  logic [7:0] shift_byte_o;

  always #2 clk = ~clk;

  hadr_tx_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .buf_off_i(buf_off_i), .abuf0_i(abuf0_i), .abuf1_i(abuf1_i),
    .txb_data_i(txb_data_i), .txb_full_i(txb_full_i),
    .ack_valid_i(ack_valid_i), .ack_nack_i(ack_nack_i),
    .shift_load_o(shift_load_o), .shift_byte_o(shift_byte_o),
    .txb_take_o(txb_take_o), .done_o(done_o), .nack_o(nack_o), .busy_o(busy_o)
  );

  typedef struct {
    int         kind;   // 1 load, 2 done, 3 nack
    logic [7:0] b;
    logic       take;
    string      req;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   running = 1'b0;

  task automatic push(input int kind, input logic [7:0] b, input logic take, input string req);
    exp_t e;
    e.kind = kind; e.b = b; e.take = take; e.req = req;
    q.push_back(e);
  endtask

  task automatic chk(input string req, input int act, input int exp_v, input string what);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  task automatic see(input int kind, input logic [7:0] b, input logic take);
    exp_t e;
    n_cmp++;
    if (q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: actual kind %0d byte %0h expected none", kind, b);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || (kind == 1 && (e.b != b || e.take != take))) begin
        n_bad++;
        $display("FAIL %s: actual kind %0d byte %0h take %0d expected kind %0d byte %0h take %0d",
                 e.req, kind, b, take, e.kind, e.b, e.take);
      end
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (shift_load_o) see(1, shift_byte_o, txb_take_o);
      if (done_o)       see(2, 8'h00, 1'b0);
      if (nack_o)       see(3, 8'h00, 1'b0);
      if (txb_take_o)   txb_full_i = 1'b0;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go(input logic [1:0] m, input logic off);
    @(negedge clk);
    mode_i = m; buf_off_i = off; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic ack(input logic nk);
    @(negedge clk);
    ack_valid_i = 1'b1; ack_nack_i = nk;
    @(negedge clk);
    ack_valid_i = 1'b0; ack_nack_i = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    // R1 reset
    cyc(3);
    chk("R1", shift_load_o, 0, "load in reset");
    chk("R1", busy_o, 0, "busy in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {shift_load_o, txb_take_o, done_o, nack_o}, 0, "strobes after reset");
    chk("R1", busy_o, 0, "busy after reset");
    running = 1'b1;

    // R2 7-bit buffered
    abuf1_i = 8'hA5; abuf0_i = 8'h11; txb_data_i = 8'hEE;
    push(1, 8'hA5, 1'b0, "R2 7-bit byte");
    go(2'd0, 1'b0);
    cyc(2);
    push(2, 8'h00, 1'b0, "R9 7-bit done");
    ack(1'b0);
    chk("R9", busy_o, 0, "idle after done");

    // R7 multi-host and code 3
    abuf1_i = 8'h3C; abuf0_i = 8'h77;
    push(1, 8'h3C, 1'b0, "R7 multi byte");
    go(2'd2, 1'b0);
    cyc(1);
    push(2, 8'h00, 1'b0, "R7 multi done");
    ack(1'b0);
    abuf1_i = 8'h6B;
    push(1, 8'h6B, 1'b0, "R7 code3 byte");
    go(2'd3, 1'b0);
    push(2, 8'h00, 1'b0, "R7 code3 done");
    ack(1'b0);

    // R3 buffer off, full
    txb_data_i = 8'h5A; txb_full_i = 1'b1;
    push(1, 8'h5A, 1'b1, "R3 txb byte");
    go(2'd0, 1'b1);
    cyc(2);
    chk("R3", txb_full_i, 0, "buffer consumed");
    push(2, 8'h00, 1'b0, "R3 done");
    ack(1'b0);

    // R4 buffer off, empty -> wait
    txb_data_i = 8'h91;
    go(2'd0, 1'b1);
    cyc(6);
    chk("R4", busy_o, 1, "busy while waiting");
    push(1, 8'h91, 1'b1, "R4 late load");
    txb_full_i = 1'b1;
    cyc(3);
    push(2, 8'h00, 1'b0, "R4 done");
    ack(1'b0);

    // R5 10-bit buffered
    abuf1_i = 8'hF2; abuf0_i = 8'h4D;
    push(1, 8'hF2, 1'b0, "R5 high byte");
    go(2'd1, 1'b0);
    cyc(3);
    push(1, 8'h4D, 1'b0, "R5 low byte");
    ack(1'b0);
    cyc(2);
    push(2, 8'h00, 1'b0, "R5 done");
    ack(1'b0);

    // R8 NACK on high byte
    abuf1_i = 8'hF4; abuf0_i = 8'h22;
    push(1, 8'hF4, 1'b0, "R8 high byte");
    go(2'd1, 1'b0);
    cyc(2);
    push(3, 8'h00, 1'b0, "R8 nack high");
    ack(1'b1);
    cyc(4);
    chk("R8", busy_o, 0, "idle after nack");

    // R8 NACK on low byte
    abuf1_i = 8'hF6; abuf0_i = 8'h33;
    push(1, 8'hF6, 1'b0, "R8 high byte 2");
    go(2'd1, 1'b0);
    push(1, 8'h33, 1'b0, "R8 low byte");
    ack(1'b0);
    cyc(1);
    push(3, 8'h00, 1'b0, "R8 nack low");
    ack(1'b1);

    // R6 10-bit buffer off, low byte waits
    txb_data_i = 8'hF0; txb_full_i = 1'b1; abuf1_i = 8'hAA; abuf0_i = 8'hBB;
    push(1, 8'hF0, 1'b1, "R6 high from txb");
    go(2'd1, 1'b1);
    cyc(3);
    ack(1'b0);
    cyc(4);
    chk("R6", busy_o, 1, "waiting for low byte");
    txb_data_i = 8'h12;
    push(1, 8'h12, 1'b1, "R6 low from txb");
    txb_full_i = 1'b1;
    cyc(3);
    push(2, 8'h00, 1'b0, "R6 done");
    ack(1'b0);

    // R10 start ignored mid-sequence, config fixed
    abuf1_i = 8'h48; abuf0_i = 8'h99;
    push(1, 8'h48, 1'b0, "R10 first byte");
    go(2'd0, 1'b0);
    abuf1_i = 8'hC3;
    go(2'd1, 1'b1);
    go(2'd1, 1'b0);
    cyc(2);
    push(2, 8'h00, 1'b0, "R10 done only");
    ack(1'b0);
    cyc(4);
    chk("R10", busy_o, 0, "idle after ignored starts");

    cyc(3);
    chk("R9", q.size(), 0, "pending expectations");
    running = 1'b0;
    summary();
    $finish;
  end
endmodule